// File: doc/BRIEF.md
# Dual/Chained Conversion Slot Sequencer

This block drives a shared analog-to-digital converter through a table of sixteen conversion slots. Each slot names one of sixteen input channels with a 4-bit code. The table can be worked by two independent sequencers, A and B, with eight slots each. It can also be worked by sequencer A alone as one chained table of sixteen slots. A trigger starts a session that converts a programmed number of slots. For each slot the block sends a channel code and a one-cycle start pulse to the converter. It waits for the converter's done strobe and stores the 12-bit sample in the result register that has the same index as the slot.

The slot pointer is not rewound between triggers. A session that ends parks the pointer on the next slot, so one table can be split across several triggered sessions. Three controls bring the pointer back to a sequencer's first slot: a loop mode, a per-sequencer clear strobe and a soft reset. Sequencer A wins the converter when both sequencers ask for it at once. Ownership of the converter changes only after a conversion has finished.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy_a`, `busy_b`, `conv_start`, `eos_a` and `eos_b` are low and all sixteen result registers read zero.
- R2: The channel code sent for slot n is `chan_table[4n+3:4n]`. It appears on `conv_chan` in the same cycle as the one-cycle `conv_start` pulse.
- R3: A session converts `sess_len`+1 consecutive slots. With `loop_en` low, the pointer then parks on the next slot, and the next trigger continues from there. With a session length of three, the first trigger fills results 0..2 and the second fills results 3..5.
- R4: The sample for slot n is written to result register n, left-justified: `{conv_data, 4'b0000}`.
- R5: With `chain_mode` low, sequencer A uses slots 0..7 and a 3-bit length (`sess_len_a[2:0]`). Sequencer B uses slots 8..15 and `sess_len_b`. Each pointer wraps from its last slot back to its first.
- R6: When both sequencers request the converter in the same cycle, sequencer A is served first.
- R7: A new conversion starts only after the previous one has completed. While a conversion is in flight, a request from either sequencer waits for it to finish.
- R8: With `loop_en` high and `full_wrap` low, each session ends with the pointer back at the first slot, and a new session starts at once.
- R9: With `loop_en` high and `full_wrap` high, sessions follow each other back to back. The pointer returns to the first slot only after the last slot of the sequencer's range.
- R10: A one-cycle `clr_a` or `clr_b` pulse forces that sequencer idle, with its pointer at its first slot.
- R11: A one-cycle `soft_rst` pulse clears both sequencers, the converter ownership and all result registers. A conversion in flight at that moment writes nothing when it completes.
- R12: A trigger that arrives while its sequencer is busy is held. A new session starts as soon as the current one ends.
- R13: `eos_a` or `eos_b` pulses for one cycle when the last conversion of a session completes. The matching busy flag is high in the cycle before.
- R14: With `chain_mode` high, sequencer A walks all sixteen slots using the 4-bit `sess_len_a`. Sequencer B stays idle and ignores `trig_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Soft reset strobe, applied one cycle later |
| chain_mode | input | 1 | 1: one 16-slot sequencer; 0: two 8-slot sequencers |
| loop_en | input | 1 | Restart a session automatically when one ends |
| full_wrap | input | 1 | In loop mode, rewind only after the last slot of the range |
| sess_len_a | input | 4 | Conversions per session minus one, sequencer A |
| sess_len_b | input | 3 | Conversions per session minus one, sequencer B |
| chan_table | input | 64 | Channel code per slot, slot n at bits 4n+3:4n |
| trig_a | input | 1 | Start strobe, sequencer A |
| trig_b | input | 1 | Start strobe, sequencer B |
| clr_a | input | 1 | Pointer clear strobe, sequencer A |
| clr_b | input | 1 | Pointer clear strobe, sequencer B |
| conv_done | input | 1 | Converter finished, one-cycle strobe |
| conv_data | input | 12 | Converter sample, valid with conv_done |
| conv_start | output | 1 | Start-of-conversion pulse |
| conv_chan | output | 4 | Channel code for the conversion being started |
| res_we | output | 1 | Result write strobe |
| res_idx | output | 4 | Slot index of the written result |
| res_data | output | 16 | Written result, left-justified |
| rd_idx | input | 4 | Result register read index |
| rd_data | output | 16 | Result register contents |
| eos_a | output | 1 | End-of-session pulse, sequencer A |
| eos_b | output | 1 | End-of-session pulse, sequencer B |
| busy_a | output | 1 | Sequencer A in a session |
| busy_b | output | 1 | Sequencer B in a session |

## Verification
A pointer in the wrong place shows up at the ports within one conversion. The first `conv_chan` after a trigger carries the wrong table entry, and the sample lands in the wrong result register. The bench reads back every register it expects to be written and at least one it expects to be untouched. A bad session counter shows as a wrong number of `conv_start` pulses before `eos_a` or `eos_b`, or before busy falls, so every scenario also compares the full ordered list of channel codes sent. Arbitration or ownership faults show within two conversions: either the channel interleaving in a contended run is wrong, or a start pulse appears while a conversion is still in flight.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_seq_engine.sv
`timescale 1ns/1ps
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             enable,
  input  logic             start,
  input  logic             rewind,
  input  logic [PTR_W-1:0] last_rel,
  input  logic [PTR_W-1:0] sess_len,
  input  logic             loop_en,
  input  logic             full_wrap,
  input  logic             gnt,
  input  logic             done,
  output logic             req,
  output logic [PTR_W-1:0] rel,
  output logic             busy,
  output logic             eos
);
  seq_state_e       state_q;
  logic [PTR_W-1:0] rel_q, cnt_q;
  logic             pend_q, eos_q;

  // pointer step inside the sequencer's own range
  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p,
                                                input logic [PTR_W-1:0] top);
    return (p == top) ? '0 : p + 1'b1;
  endfunction

  logic [PTR_W-1:0] rel_inc;
  logic             last_conv;
  assign rel_inc   = step_ptr(rel_q, last_rel);
  assign last_conv = (cnt_q == sess_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rel_q   <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      eos_q   <= 1'b0;
    end else if (clr || !enable || rewind) begin
      state_q <= ST_IDLE;
      rel_q   <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      eos_q   <= 1'b0;
    end else begin
      eos_q <= 1'b0;
      if (start && state_q != ST_IDLE) pend_q <= 1'b1;
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_REQ;
          cnt_q   <= '0;
        end
        ST_REQ: if (gnt) state_q <= ST_WAIT;
        ST_WAIT: if (done) begin
          if (!last_conv) begin
            rel_q   <= rel_inc;
            cnt_q   <= cnt_q + 1'b1;
            state_q <= ST_REQ;
          end else begin
            eos_q   <= 1'b1;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
            rel_q   <= (loop_en && !full_wrap) ? '0 : rel_inc;
            state_q <= (loop_en || pend_q || start) ? ST_REQ : ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req  = (state_q == ST_REQ);
  assign busy = (state_q != ST_IDLE);
  assign rel  = rel_q;
  assign eos  = eos_q;
endmodule

// File: rtl/adc_seq_arb.sv
`timescale 1ns/1ps
module adc_seq_arb #(
  parameter int N_REQ = 2
) (
  input  logic             free,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] gnt
);
  // fixed priority, lowest index wins; only grants while converter is free
  always_comb begin
    gnt = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (free && req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_seq_results.sv
`timescale 1ns/1ps
module adc_seq_results #(
  parameter int NUM_SLOTS = 16,
  parameter int RES_W     = 16,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [RES_W-1:0] wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [RES_W-1:0] rdata
);
  logic [RES_W-1:0] bank_q [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            bank_q[g] <= '0;
      else if (clr)                          bank_q[g] <= '0;
      else if (we && widx == IDX_W'(g))      bank_q[g] <= wdata;
    end
  end

  assign rdata = bank_q[ridx];
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl #(
  parameter int NUM_SLOTS = 16,
  parameter int CH_W      = 4,
  parameter int DATA_W    = 12,
  parameter int RES_W     = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int HALF     = NUM_SLOTS / 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      soft_rst,
  input  logic                      chain_mode,
  input  logic                      loop_en,
  input  logic                      full_wrap,
  input  logic [SLOT_W-1:0]         sess_len_a,
  input  logic [SLOT_W-2:0]         sess_len_b,
  input  logic [NUM_SLOTS*CH_W-1:0] chan_table,
  input  logic                      trig_a,
  input  logic                      trig_b,
  input  logic                      clr_a,
  input  logic                      clr_b,
  input  logic                      conv_done,
  input  logic [DATA_W-1:0]         conv_data,
  output logic                      conv_start,
  output logic [CH_W-1:0]           conv_chan,
  output logic                      res_we,
  output logic [SLOT_W-1:0]         res_idx,
  output logic [RES_W-1:0]          res_data,
  input  logic [SLOT_W-1:0]         rd_idx,
  output logic [RES_W-1:0]          rd_data,
  output logic                      eos_a,
  output logic                      eos_b,
  output logic                      busy_a,
  output logic                      busy_b
);
  localparam int NSEQ = 2;

  function automatic logic [RES_W-1:0] ljust(input logic [DATA_W-1:0] d);
    return {d, {(RES_W - DATA_W){1'b0}}};
  endfunction

  // soft reset is registered and self-clears after one cycle
  logic soft_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_q <= 1'b0;
    else        soft_q <= soft_rst;
  end

  // per-sequencer configuration
  logic [SLOT_W-1:0] last_rel [NSEQ];
  logic [SLOT_W-1:0] len_sel  [NSEQ];
  logic [SLOT_W-1:0] rel      [NSEQ];
  logic [SLOT_W-1:0] slot_of  [NSEQ];
  logic [NSEQ-1:0]   trig_v, clr_v, en_v, req_v, gnt_v, done_v, busy_v, eos_v;

  assign last_rel[0] = chain_mode ? SLOT_W'(NUM_SLOTS - 1) : SLOT_W'(HALF - 1);
  assign last_rel[1] = SLOT_W'(HALF - 1);
  assign len_sel[0]  = chain_mode ? sess_len_a : {1'b0, sess_len_a[SLOT_W-2:0]};
  assign len_sel[1]  = {1'b0, sess_len_b};
  assign trig_v      = {trig_b, trig_a};
  assign clr_v       = {clr_b, clr_a};
  assign en_v        = {~chain_mode, 1'b1};

  // converter ownership
  logic              cbusy_q, owner_q;
  logic [SLOT_W-1:0] oslot_q;
  logic              conv_free, conv_fin, any_gnt;
  logic [SLOT_W-1:0] gslot;

  assign conv_free = ~cbusy_q;
  assign conv_fin  = cbusy_q & conv_done;
  assign any_gnt   = |gnt_v;
  assign gslot     = gnt_v[0] ? slot_of[0] : slot_of[1];

  for (genvar s = 0; s < NSEQ; s++) begin : g_seq
    assign slot_of[s] = rel[s] + SLOT_W'(s * HALF);
    assign done_v[s]  = conv_fin & (owner_q == s[0]);
    adc_seq_engine #(.PTR_W(SLOT_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (soft_q),
      .enable    (en_v[s]),
      .start     (trig_v[s]),
      .rewind    (clr_v[s]),
      .last_rel  (last_rel[s]),
      .sess_len  (len_sel[s]),
      .loop_en   (loop_en),
      .full_wrap (full_wrap),
      .gnt       (gnt_v[s]),
      .done      (done_v[s]),
      .req       (req_v[s]),
      .rel       (rel[s]),
      .busy      (busy_v[s]),
      .eos       (eos_v[s])
    );
  end

  adc_seq_arb #(.N_REQ(NSEQ)) u_arb (
    .free (conv_free),
    .req  (req_v),
    .gnt  (gnt_v)
  );

  logic            start_q, we_q;
  logic [CH_W-1:0] chan_q;
  logic [SLOT_W-1:0] widx_q;
  logic [RES_W-1:0]  wdat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cbusy_q <= 1'b0;
      owner_q <= 1'b0;
      oslot_q <= '0;
      start_q <= 1'b0;
      chan_q  <= '0;
      we_q    <= 1'b0;
      widx_q  <= '0;
      wdat_q  <= '0;
    end else if (soft_q) begin
      cbusy_q <= 1'b0;
      owner_q <= 1'b0;
      oslot_q <= '0;
      start_q <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      start_q <= any_gnt;
      we_q    <= conv_fin;
      if (any_gnt) begin
        cbusy_q <= 1'b1;
        owner_q <= gnt_v[1];
        oslot_q <= gslot;
        chan_q  <= chan_table[int'(gslot) * CH_W +: CH_W];
      end else if (conv_fin) begin
        cbusy_q <= 1'b0;
      end
      if (conv_fin) begin
        widx_q <= oslot_q;
        wdat_q <= ljust(conv_data);
      end
    end
  end

  adc_seq_results #(.NUM_SLOTS(NUM_SLOTS), .RES_W(RES_W)) u_res (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (soft_q),
    .we    (conv_fin),
    .widx  (oslot_q),
    .wdata (ljust(conv_data)),
    .ridx  (rd_idx),
    .rdata (rd_data)
  );

  assign conv_start = start_q;
  assign conv_chan  = chan_q;
  assign res_we     = we_q;
  assign res_idx    = widx_q;
  assign res_data   = wdat_q;
  assign eos_a      = eos_v[0];
  assign eos_b      = eos_v[1];
  assign busy_a     = busy_v[0];
  assign busy_b     = busy_v[1];
endmodule

// File: rtl/adc_seq_chk.sv
`timescale 1ns/1ps
module adc_seq_chk #(
  parameter int RES_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             chain_mode,
  input logic             conv_start,
  input logic             conv_done,
  input logic             res_we,
  input logic [RES_W-1:0] res_data,
  input logic             eos_a,
  input logic             eos_b,
  input logic             busy_a,
  input logic             busy_b
);
  // the checker's own view of an outstanding conversion
  logic outst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          outst_q <= 1'b0;
    else if (soft_rst)   outst_q <= 1'b0;
    else if (conv_start) outst_q <= 1'b1;
    else if (conv_done)  outst_q <= 1'b0;
  end

  a_r7_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !outst_q);

  a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r4_low_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (res_data[3:0] == 4'h0));

  a_r13_eos_a_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eos_a |-> $past(busy_a));

  a_r13_eos_b_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eos_b |-> $past(busy_b));

  a_r14_chain_b_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_mode && $past(chain_mode)) |-> !busy_b);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .chain_mode (chain_mode),
  .conv_start (conv_start),
  .conv_done  (conv_done),
  .res_we     (res_we),
  .res_data   (res_data),
  .eos_a      (eos_a),
  .eos_b      (eos_b),
  .busy_a     (busy_a),
  .busy_b     (busy_b)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic soft_rst = 0, chain_mode = 1, loop_en = 0, full_wrap = 0;
  logic [3:0] sess_len_a = 0;
  logic [2:0] sess_len_b = 0;
  logic [63:0] chan_table;
  logic trig_a = 0, trig_b = 0, clr_a = 0, clr_b = 0;
  logic conv_done = 0;
  logic [11:0] conv_data = 0;
  logic conv_start, res_we, eos_a, eos_b, busy_a, busy_b;
  logic [3:0] conv_chan, res_idx, rd_idx = 0;
  logic [15:0] res_data, rd_data;

  int checks = 0, errs = 0;
  bit done_flag = 0;
  logic [7:0] tag = 8'h00;
  logic [3:0] log_ch [64];
  int log_n = 0, eos_a_n = 0;
  int lat_cnt = 0;
  logic [3:0] cur_ch = 0;

  always #10 clk = ~clk;

  adc_seq_ctrl u_dut (.*);

  function automatic logic [3:0] tb_chan(input int s);
    return 4'((s * 5 + 2) % 16);
  endfunction

  function automatic logic [15:0] exp_res(input int s, input logic [7:0] t);
    return {tb_chan(s), t, 4'h0};
  endfunction

  // converter model and stimulus log, all at the falling edge
  always @(negedge clk) begin
    if (lat_cnt > 0) begin
      lat_cnt--;
      if (lat_cnt == 0) begin
        conv_done = 1'b1;
        conv_data = {cur_ch, tag};
      end
    end else begin
      conv_done = 1'b0;
    end
    if (conv_start) begin
      if (log_n < 64) log_ch[log_n] = conv_chan;
      log_n++;
      cur_ch  = conv_chan;
      lat_cnt = 3;
    end
    if (eos_a) eos_a_n++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int idx, output logic [15:0] v);
    @(negedge clk);
    rd_idx = 4'(idx);
    #1 v = rd_data;
  endtask

  task automatic pulse_trig(input bit a, input bit b);
    @(negedge clk);
    trig_a = a; trig_b = b;
    @(negedge clk);
    trig_a = 0; trig_b = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    repeat (2) @(negedge clk);
    while ((busy_a || busy_b) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_log(input int n);
    int k = 0;
    while (log_n < n && k < 5000) begin
      @(negedge clk);
      #1;
      k++;
    end
  endtask

  task automatic do_soft_rst();
    @(negedge clk);
    soft_rst = 1;
    @(negedge clk);
    soft_rst = 0;
    repeat (8) @(negedge clk);
    log_n = 0; eos_a_n = 0;
  endtask

  task automatic chk_log(input string req, input int s0, input int n, input int step_wrap);
    for (int i = 0; i < n; i++)
      chk(req, log_ch[i], tb_chan(s0 + (i % step_wrap)));
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 busy_a", busy_a, 0);
    chk("R1 busy_b", busy_b, 0);
    chk("R1 conv_start", conv_start, 0);
    chk("R1 eos", {eos_a, eos_b}, 0);
    for (int i = 0; i < 16; i++) begin
      rd(i, v);
      chk("R1 result zero", v, 0);
    end
  endtask

  task automatic t_split();
    logic [15:0] v;
    chain_mode = 1; sess_len_a = 2; loop_en = 0;
    tag = 8'h11; log_n = 0; eos_a_n = 0;
    pulse_trig(1, 0); wait_idle();
    chk("R3 first session count", log_n, 3);
    chk_log("R2 channel order first", 0, 3, 64);
    for (int i = 0; i < 3; i++) begin
      rd(i, v);
      chk("R4 result slot first", v, exp_res(i, 8'h11));
    end
    rd(3, v); chk("R3 slot 3 untouched", v, 0);
    tag = 8'h22; log_n = 0;
    pulse_trig(1, 0); wait_idle();
    chk_log("R3 parked resume", 3, 3, 64);
    for (int i = 3; i < 6; i++) begin
      rd(i, v);
      chk("R3 second session result", v, exp_res(i, 8'h22));
    end
    rd(6, v); chk("R3 slot 6 untouched", v, 0);
    chk("R13 eos per session", eos_a_n, 2);
  endtask

  task automatic t_rewind();
    logic [15:0] v;
    @(negedge clk); clr_a = 1; @(negedge clk); clr_a = 0;
    tag = 8'h33; log_n = 0;
    pulse_trig(1, 0); wait_idle();
    chk("R10 restart at slot 0", log_ch[0], tb_chan(0));
    rd(0, v); chk("R10 slot 0 rewritten", v, exp_res(0, 8'h33));
  endtask

  task automatic t_pending();
    do_soft_rst();
    chain_mode = 1; sess_len_a = 1; tag = 8'h44;
    pulse_trig(1, 0);
    wait_log(1);
    pulse_trig(1, 0);
    wait_idle();
    chk("R12 pending session count", log_n, 4);
    chk_log("R12 pending order", 0, 4, 64);
    chk("R12 two eos", eos_a_n, 2);
  endtask

  task automatic t_soft();
    logic [15:0] v;
    tag = 8'h55;
    pulse_trig(1, 0);
    wait_log(1);
    do_soft_rst();
    chk("R11 idle after soft reset", busy_a, 0);
    rd(0, v); chk("R11 result 0 cleared", v, 0);
    rd(3, v); chk("R11 result 3 cleared", v, 0);
  endtask

  task automatic t_dual_b();
    logic [15:0] v;
    chain_mode = 0; sess_len_b = 1; tag = 8'h66;
    do_soft_rst();
    pulse_trig(0, 1); wait_idle();
    chk_log("R5 seq B slots", 8, 2, 64);
    rd(8, v); chk("R5 result 8", v, exp_res(8, 8'h66));
    rd(9, v); chk("R5 result 9", v, exp_res(9, 8'h66));
    rd(0, v); chk("R5 slot 0 untouched", v, 0);
  endtask

  task automatic t_priority();
    do_soft_rst();
    sess_len_a = 0; sess_len_b = 0;
    pulse_trig(1, 1); wait_idle();
    chk("R6 A first", log_ch[0], tb_chan(0));
    chk("R6 B second", log_ch[1], tb_chan(8));
  endtask

  task automatic t_boundary();
    do_soft_rst();
    sess_len_a = 0; sess_len_b = 2;
    pulse_trig(0, 1);
    wait_log(1);
    pulse_trig(1, 0);
    wait_idle();
    chk("R7 count", log_n, 4);
    chk("R7 B holds first", log_ch[0], tb_chan(8));
    chk("R7 A at boundary", log_ch[1], tb_chan(0));
    chk("R7 B resumes", log_ch[2], tb_chan(9));
    chk("R7 B last", log_ch[3], tb_chan(10));
  endtask

  task automatic t_loop();
    do_soft_rst();
    sess_len_a = 1; loop_en = 1; full_wrap = 0;
    pulse_trig(1, 0);
    wait_log(6);
    loop_en = 0;
    wait_idle();
    chk("R8 loop count", log_n, 6);
    chk_log("R8 rewind each session", 0, 6, 2);
  endtask

  task automatic t_wrap();
    do_soft_rst();
    sess_len_a = 2; loop_en = 1; full_wrap = 1;
    pulse_trig(1, 0);
    wait_log(9);
    loop_en = 0;
    wait_idle();
    full_wrap = 0;
    chk("R9 wrap count", log_n, 9);
    chk_log("R9 walk to last slot", 0, 9, 8);
  endtask

  task automatic t_chain16();
    logic [15:0] v;
    chain_mode = 1;
    do_soft_rst();
    sess_len_a = 15; tag = 8'h77;
    pulse_trig(1, 1); wait_idle();
    chk("R14 sixteen conversions", log_n, 16);
    chk_log("R14 chained order", 0, 16, 64);
    rd(15, v); chk("R14 result 15", v, exp_res(15, 8'h77));
    chk("R14 B idle", busy_b, 0);
  endtask

  initial begin
    chan_table = '0;
    for (int i = 0; i < 16; i++) chan_table[i*4 +: 4] = tb_chan(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_split();
    t_rewind();
    t_pending();
    t_soft();
    t_dual_b();
    t_priority();
    t_boundary();
    t_loop();
    t_wrap();
    t_chain16();
    if (!done_flag) begin
      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errs++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end
endmodule